// File: doc/BRIEF.md
# Per-Context Branch Confidence Tracker

This block keeps one confidence figure for each of eight hardware thread contexts in a multithreaded core. The figure is the length of the current streak of correctly predicted branches for that context. The streak counts every branch the context resolves, not one branch in particular. Mispredictions tend to come in bursts, so a long streak is taken as a sign that the next prediction can be trusted. A fetch policy reads one high/low bit per context, which compares the streak against a programmable threshold. It can use this bit to stall or to deprioritise threads whose next branch is doubtful.

Branch outcomes arrive on a parameterised number of resolution ports. Each port carries a valid bit, a context number and a correct/incorrect flag. A per-context flush vector clears streaks when a context's pipeline is squashed. A second confidence source is also provided. The fetch logic presents two flags, one from the local predictor and one from the global predictor. Each flag says whether that predictor's counter for the branch in hand is in a saturated state (strongly taken or strongly not taken). The block returns how many of the two are strong. In strength mode the query's high/low result compares that count against the same threshold.

Top module: `branch_conf_tracker`

## Requirements
- R1: After synchronous reset every streak counter is 0, so with a threshold of 1 or more every bit of `ctx_hi` is 0.
- R2: Each valid resolution with `res_ok`=1 adds one to the streak of the named context, whichever branch it belongs to.
- R3: A valid resolution with `res_ok`=0 sets the named context's streak to 0 and leaves all other contexts unchanged.
- R4: A streak is 4 bits wide and stops at 15; further correct resolutions keep it at 15.
- R5: All resolutions in one cycle are applied. If several name the same context, any incorrect one clears it; otherwise it advances by the number of correct ones (saturating).
- R6: `flush[c]`=1 clears context c at the next edge, taking priority over resolutions for c in the same cycle.
- R7: `ctx_hi[c]` is 1 exactly when context c's streak is greater than or equal to `thresh`; thresholds 1, 3 and 7 all work.
- R8: `q_dist` shows the streak of context `q_ctx` as held before any update that happens at the coming edge.
- R9: `q_strength` equals the number of set bits among `q_loc_strong` and `q_glb_strong` (0, 1 or 2).
- R10: `q_hi` is `q_strength >= thresh` when `q_strength_mode`=1 (threshold 1 = either strong, 2 = both), and `ctx_hi[q_ctx]` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | RES_PORTS | Resolution valid per port |
| res_ctx | input | RES_PORTS*3 | Context number per port, port p in bits [3p+2:3p] |
| res_ok | input | RES_PORTS | 1 = prediction was correct |
| flush | input | 8 | Per-context clear |
| thresh | input | 4 | Confidence threshold |
| q_strength_mode | input | 1 | 1 = query uses predictor strength, 0 = streak |
| q_ctx | input | 3 | Context being queried |
| q_loc_strong | input | 1 | Local predictor counter is saturated |
| q_glb_strong | input | 1 | Global predictor counter is saturated |
| ctx_hi | output | 8 | Per-context high-confidence bit |
| q_dist | output | 4 | Streak of the queried context |
| q_strength | output | 2 | Count of strong predictor counters |
| q_hi | output | 1 | High/low result of the query |

## Verification
Several things can hit one context in the same cycle: two resolution ports, or a resolution and a flush. The bench drives both ports at one context with mixed and with matching outcomes, and it raises a flush together with a correct resolution. It expects a cleared streak whenever a miss or flush is present and a jump of two when both ports are correct. A query of a context that is being updated is also judged every cycle against the reference model's pre-edge value.

// File: rtl/conf_pkg.sv
package conf_pkg;
    localparam int N_CTX  = 8;
    localparam int DIST_W = 4;
    localparam int CTX_W  = $clog2(N_CTX);

    typedef logic [DIST_W-1:0] streak_t;
    typedef logic [CTX_W-1:0]  ctx_id_t;

    typedef struct packed {
        logic    vld;
        ctx_id_t ctx;
        logic    ok;
    } resolve_t;

    function automatic logic [1:0] strong_count(input logic loc, input logic glb);
        return {1'b0, loc} + {1'b0, glb};
    endfunction
endpackage

// File: rtl/conf_event_route.sv
module conf_event_route
    import conf_pkg::*;
#(
    parameter int RES_PORTS = 2,
    parameter int CTX_ID    = 0,
    localparam int INC_W    = $clog2(RES_PORTS + 1)
) (
    input  resolve_t           evt [RES_PORTS],
    input  logic               flush_i,
    output logic               clr_o,
    output logic [INC_W-1:0]   inc_o
);
    logic miss;

    always_comb begin
        miss  = 1'b0;
        inc_o = '0;
        for (int p = 0; p < RES_PORTS; p++) begin
            if (evt[p].vld && (evt[p].ctx == ctx_id_t'(CTX_ID))) begin
                if (evt[p].ok) inc_o = inc_o + INC_W'(1);
                else           miss  = 1'b1;
            end
        end
        clr_o = flush_i | miss;
    end
endmodule

// File: rtl/conf_dist_ctr.sv
module conf_dist_ctr
    import conf_pkg::*;
#(
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output streak_t          cnt
);
    localparam int      SUM_W = DIST_W + INC_W;
    localparam streak_t TOP   = '1;

    logic [SUM_W-1:0] sum;

    always_comb sum = SUM_W'(cnt) + SUM_W'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc != '0)
            cnt <= (sum > SUM_W'(TOP)) ? TOP : sum[DIST_W-1:0];
    end

    // R3, R6: a clear request empties the streak
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
    // R4: a full counter stays full while not cleared
    a_r4_hold_top: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP && !clr) |=> cnt == TOP);
    // R2: without a clear the streak never shrinks
    a_r2_no_decrease: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt));
    // R3: untouched contexts keep their value
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc == '0) |=> $stable(cnt));
endmodule

// File: rtl/branch_conf_tracker.sv
module branch_conf_tracker
    import conf_pkg::*;
#(
    parameter int RES_PORTS = 2,
    localparam int INC_W    = $clog2(RES_PORTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [RES_PORTS-1:0]       res_vld,
    input  logic [RES_PORTS*CTX_W-1:0] res_ctx,
    input  logic [RES_PORTS-1:0]       res_ok,
    input  logic [N_CTX-1:0]           flush,
    input  logic [DIST_W-1:0]          thresh,
    input  logic                       q_strength_mode,
    input  logic [CTX_W-1:0]           q_ctx,
    input  logic                       q_loc_strong,
    input  logic                       q_glb_strong,
    output logic [N_CTX-1:0]           ctx_hi,
    output logic [DIST_W-1:0]          q_dist,
    output logic [1:0]                 q_strength,
    output logic                       q_hi
);
    resolve_t evt [RES_PORTS];
    streak_t  streak [N_CTX];

    for (genvar p = 0; p < RES_PORTS; p++) begin : g_port
        always_comb begin
            evt[p].vld = res_vld[p];
            evt[p].ctx = res_ctx[p*CTX_W +: CTX_W];
            evt[p].ok  = res_ok[p];
        end
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic             clr;
        logic [INC_W-1:0] inc;

        conf_event_route #(.RES_PORTS(RES_PORTS), .CTX_ID(c)) u_route (
            .evt     (evt),
            .flush_i (flush[c]),
            .clr_o   (clr),
            .inc_o   (inc)
        );

        conf_dist_ctr #(.INC_W(INC_W)) u_ctr (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .inc (inc),
            .cnt (streak[c])
        );

        always_comb ctx_hi[c] = (streak[c] >= thresh);

        // R6: flush wins over same-cycle resolutions
        a_r6_flush_wins: assert property (@(posedge clk) disable iff (rst)
            flush[c] |=> ctx_hi[c] == (thresh == '0));
    end

    always_comb begin
        q_dist     = streak[q_ctx];
        q_strength = strong_count(q_loc_strong, q_glb_strong);
        q_hi       = q_strength_mode ? (DIST_W'(q_strength) >= thresh)
                                     : ctx_hi[q_ctx];
    end

    // R9: strength is never above two
    a_r9_strength_range: assert property (@(posedge clk) disable iff (rst)
        q_strength != 2'd3);
    // R10: both strong with threshold 2 in strength mode is high
    a_r10_both_strong: assert property (@(posedge clk) disable iff (rst)
        (q_strength_mode && q_loc_strong && q_glb_strong && thresh == 4'd2) |-> q_hi);
    // R1: counters are empty right after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> q_dist == '0);
endmodule

// File: tb/branch_conf_tracker_test.sv
module branch_conf_tracker_test;
    localparam int P = 2;

    logic       clk = 0;
    logic       rst;
    logic [1:0] res_vld, res_ok;
    logic [5:0] res_ctx;
    logic [7:0] flush;
    logic [3:0] thresh;
    logic       q_strength_mode, q_loc_strong, q_glb_strong;
    logic [2:0] q_ctx;
    logic [7:0] ctx_hi;
    logic [3:0] q_dist;
    logic [1:0] q_strength;
    logic       q_hi;

    int checks = 0;
    int errors = 0;
    int model [8];
    bit done = 0;

    always #4 clk = ~clk;

    branch_conf_tracker #(.RES_PORTS(P)) uut (
        .clk(clk), .rst(rst), .res_vld(res_vld), .res_ctx(res_ctx), .res_ok(res_ok),
        .flush(flush), .thresh(thresh), .q_strength_mode(q_strength_mode),
        .q_ctx(q_ctx), .q_loc_strong(q_loc_strong), .q_glb_strong(q_glb_strong),
        .ctx_hi(ctx_hi), .q_dist(q_dist), .q_strength(q_strength), .q_hi(q_hi)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        res_vld = '0; res_ok = '0; res_ctx = '0; flush = '0;
    endtask

    task automatic port(input int p, input int ctx, input bit ok);
        res_vld[p] = 1'b1;
        res_ok[p]  = ok;
        res_ctx[p*3 +: 3] = 3'(ctx);
    endtask

    // compare against reference, then advance reference as the edge will
    task automatic step();
        logic [7:0] exp_hi;
        int s;
        int miss [8];
        int add [8];
        #1;
        for (int c = 0; c < 8; c++) exp_hi[c] = (model[c] >= int'(thresh));
        check("R7 ctx_hi", int'(ctx_hi), int'(exp_hi));
        check("R8 q_dist pre-update", int'(q_dist), model[q_ctx]);
        s = int'(q_loc_strong) + int'(q_glb_strong);
        check("R9 q_strength", int'(q_strength), s);
        check("R10 q_hi", int'(q_hi),
              q_strength_mode ? int'(s >= int'(thresh)) : int'(exp_hi[q_ctx]));
        for (int c = 0; c < 8; c++) begin miss[c] = 0; add[c] = 0; end
        for (int p = 0; p < P; p++)
            if (res_vld[p]) begin
                if (res_ok[p]) add[res_ctx[p*3 +: 3]]++;
                else           miss[res_ctx[p*3 +: 3]] = 1;
            end
        for (int c = 0; c < 8; c++) begin
            if (flush[c] || miss[c] != 0) model[c] = 0;
            else model[c] = (model[c] + add[c] > 15) ? 15 : model[c] + add[c];
        end
        @(negedge clk);
    endtask

    task automatic peek(input string tag, input int ctx, input int exp);
        idle();
        q_strength_mode = 0;
        q_ctx = 3'(ctx);
        #1;
        check(tag, int'(q_dist), exp);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++) model[c] = 0;
        rst = 1; idle();
        thresh = 4'd1; q_strength_mode = 0; q_ctx = 0; q_loc_strong = 0; q_glb_strong = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1 ctx_hi after reset", int'(ctx_hi), 0);
        check("R1 q_dist after reset", int'(q_dist), 0);
        @(negedge clk);

        // R2: streak over distinct branches of context 2
        thresh = 4'd3;
        for (int i = 0; i < 5; i++) begin idle(); port(i % 2, 2, 1); step(); end
        peek("R2 ctx2 streak", 2, 5);
        for (int i = 0; i < 2; i++) begin idle(); port(0, 5, 1); step(); end
        // R3 and R5: miss on ctx2 and hit on ctx5 in one cycle
        idle(); port(0, 2, 0); port(1, 5, 1); step();
        peek("R3 ctx2 cleared", 2, 0);
        peek("R5 ctx5 advanced", 5, 3);
        peek("R3 ctx0 untouched", 0, 0);
        #1; check("R7 thresh3 ctx5 hi", int'(ctx_hi[5]), 1);
        thresh = 4'd7; #1; check("R7 thresh7 ctx5 lo", int'(ctx_hi[5]), 0);
        thresh = 4'd1; #1; check("R7 thresh1 ctx2 lo", int'(ctx_hi[2]), 0);
        @(negedge clk);

        // R4: saturation
        for (int i = 0; i < 10; i++) begin idle(); port(0, 1, 1); port(1, 1, 1); step(); end
        peek("R4 ctx1 saturated", 1, 15);
        // R6: flush with correct resolution
        idle(); port(0, 1, 1); flush[1] = 1; q_ctx = 1; step();
        peek("R6 flush wins", 1, 0);
        // R5: same context on both ports
        idle(); port(0, 4, 1); port(1, 4, 1); step();
        peek("R5 double hit", 4, 2);
        idle(); port(0, 4, 1); port(1, 4, 0); step();
        peek("R5 mixed clears", 4, 0);

        // R9, R10: strength mode
        q_strength_mode = 1;
        for (int t = 1; t <= 2; t++)
            for (int v = 0; v < 4; v++) begin
                idle(); thresh = 4'(t); q_loc_strong = v[0]; q_glb_strong = v[1];
                #1;
                check("R10 strength threshold", int'(q_hi), int'(v[0] + v[1] >= t));
                step();
            end

        // random traffic with thresholds 1, 3, 7
        for (int i = 0; i < 600; i++) begin
            int r;
            idle();
            r = $urandom_range(0, 2);
            thresh = (r == 0) ? 4'd1 : (r == 1) ? 4'd3 : 4'd7;
            for (int p = 0; p < P; p++)
                if ($urandom_range(0, 3) != 0)
                    port(p, $urandom_range(0, 7), $urandom_range(0, 7) != 0);
            if ($urandom_range(0, 15) == 0) flush = 8'(1 << $urandom_range(0, 7));
            q_ctx = 3'($urandom_range(0, 7));
            q_strength_mode = $urandom_range(0, 1);
            q_loc_strong = $urandom_range(0, 1);
            q_glb_strong = $urandom_range(0, 1);
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule